// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data-memory addresses from a small file of pointer sets. Each set holds four registers: an index, a step, a base and a span. On an access request the block presents the current index of the chosen set as the address and, in the same clock edge, writes a post-modified index back into that set. The update can be plain linear, circular inside a buffer of any start address and any length, or linear with a bit-reversed address output for FFT reordering.

Two copies of the whole pointer file exist: a primary and a secondary bank. A bank-select input picks the active copy. Accesses, register writes and register reads all work on the active bank, and the inactive bank keeps its contents. Software loads the registers through a simple write port and reads them back through a combinational read port. The step used by an access comes either from the set's step register or from an immediate supplied with the request.

Top module: `cbag_top`

## Requirements
- R1: After reset `addr_valid` is 0, every register of every set in both banks reads 0, and the primary bank (0) is active.
- R2: A write stores `wr_data` into the field picked by `wr_field` of set `wr_set` in the active bank (field codes: 0 index, 1 step, 2 base, 3 span). `rd_data` shows the field picked by `rd_field` of set `rd_set` combinationally. Writing the base also loads the index with the same value.
- R3: An access raised in one cycle gives `addr_valid`=1 in the next cycle only. In every mode other than bit-reverse, `addr_out` equals the set's index before the update.
- R4: With span 0 in mode 0 or 3, the new index is index + step, modulo 2^AW. The step is a two's-complement value.
- R5: With span L not 0 in mode 0 or 3, the sum index + step is reduced by L when it reaches base + L or more, so the index stays inside the buffer for any base.
- R6: With span L not 0 in mode 0 or 3, the sum is increased by L when it falls below base, so a negative step also wraps.
- R7: With `acc_use_imm`=1 the immediate `acc_imm` is the step instead of the step register, and the step register is left unchanged.
- R8: In mode 1 (bit-reverse) `addr_out` is the index with its low BREV_BITS bits mirrored and the upper bits unchanged. The index advances by the step with no wrap, even when the span is not 0.
- R9: Mode 2 always updates linearly and ignores the span. Mode 3 behaves like mode 0.
- R10: `bank_sel` is registered. An access, write or read uses the new bank from the cycle after `bank_sel` changes. The inactive bank keeps its contents.
- R11: When a write and an access reach the same set in the same cycle, the written value is what the set holds afterwards. The access still outputs the old index.
- R12: An access changes only the index of its own set in the active bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Requested bank: 0 primary, 1 secondary |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | SW | Set number for the write |
| wr_field | input | 2 | Field code for the write |
| wr_data | input | AW | Write data |
| rd_set | input | SW | Set number for the read |
| rd_field | input | 2 | Field code for the read |
| rd_data | output | AW | Read data from the active bank |
| acc_valid | input | 1 | Access request |
| acc_set | input | SW | Set used by the access |
| acc_mode | input | 2 | 0 auto, 1 bit-reverse, 2 forced linear, 3 auto |
| acc_use_imm | input | 1 | Use `acc_imm` as the step |
| acc_imm | input | AW | Immediate step, two's complement |
| addr_valid | output | 1 | Address output is valid |
| addr_out | output | AW | Generated address |

## Verification
A corrupted index shows up as a wrong `addr_out` on the next access to that set, one cycle after the request. It can also be seen at once through the read port. A wrong wrap decision lets the index leave the buffer, so the address sequence breaks at the first access that crosses either buffer edge. A bank that switches too early or too late makes the access issued in the switching cycle return the address from the wrong bank. The bench therefore checks every address in order against a shadow model and reads the registers back after each stimulus.

// File: rtl/cbag_pkg.sv
package cbag_pkg;

    typedef enum logic [1:0] {
        FLD_INDEX = 2'd0,
        FLD_STEP  = 2'd1,
        FLD_BASE  = 2'd2,
        FLD_SPAN  = 2'd3
    } field_e;

    typedef enum logic [1:0] {
        MODE_AUTO     = 2'd0,
        MODE_BITREV   = 2'd1,
        MODE_LINEAR   = 2'd2,
        MODE_AUTO_ALT = 2'd3
    } mode_e;

    localparam int MAX_AW = 64;

    // Mirror the lowest n bits of v and keep the rest as they are.
    function automatic logic [MAX_AW-1:0] reverse_low(input logic [MAX_AW-1:0] v, input int n);
        logic [MAX_AW-1:0] r;
        r = v;
        for (int i = 0; i < MAX_AW; i++) begin
            if (i < n) r[i] = v[n-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/cbag_bank.sv
module cbag_bank
    import cbag_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NSETS = 4,
    localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_set,
    input  field_e        wr_field,
    input  logic [AW-1:0] wr_data,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_set,
    input  logic [AW-1:0] upd_idx,
    input  logic [SW-1:0] rd_set,
    input  field_e        rd_field,
    output logic [AW-1:0] rd_data,
    input  logic [SW-1:0] acc_set,
    output logic [AW-1:0] acc_idx,
    output logic [AW-1:0] acc_step,
    output logic [AW-1:0] acc_base,
    output logic [AW-1:0] acc_span
);

    logic [AW-1:0] idx_q  [NSETS];
    logic [AW-1:0] step_q [NSETS];
    logic [AW-1:0] base_q [NSETS];
    logic [AW-1:0] span_q [NSETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                idx_q[s]  <= '0;
                step_q[s] <= '0;
                base_q[s] <= '0;
                span_q[s] <= '0;
            end
        end else begin
            if (upd_en) idx_q[upd_set] <= upd_idx;
            // a software write lands after the post-modify and wins
            if (wr_en) begin
                case (wr_field)
                    FLD_INDEX: idx_q[wr_set]  <= wr_data;
                    FLD_STEP:  step_q[wr_set] <= wr_data;
                    FLD_BASE: begin
                        base_q[wr_set] <= wr_data;
                        idx_q[wr_set]  <= wr_data;
                    end
                    default:   span_q[wr_set] <= wr_data;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_field)
            FLD_INDEX: rd_data = idx_q[rd_set];
            FLD_STEP:  rd_data = step_q[rd_set];
            FLD_BASE:  rd_data = base_q[rd_set];
            default:   rd_data = span_q[rd_set];
        endcase
    end

    assign acc_idx  = idx_q[acc_set];
    assign acc_step = step_q[acc_set];
    assign acc_base = base_q[acc_set];
    assign acc_span = span_q[acc_set];

endmodule

// File: rtl/cbag_update.sv
module cbag_update
    import cbag_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BREV_BITS = 8
) (
    input  mode_e         mode,
    input  logic [AW-1:0] cur_idx,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] span,
    output logic [AW-1:0] next_idx,
    output logic [AW-1:0] addr
);

    localparam int EW = AW + 2;

    logic signed [EW-1:0] sum_x, base_x, span_x, lim_x, wrap_x;
    logic                 circ_on;
    logic [MAX_AW-1:0]    rev_full;

    always_comb begin
        sum_x  = $signed({2'b00, cur_idx}) + $signed({{2{step[AW-1]}}, step});
        base_x = $signed({2'b00, base});
        span_x = $signed({2'b00, span});
        lim_x  = base_x + span_x;
        if (sum_x >= lim_x)      wrap_x = sum_x - span_x;
        else if (sum_x < base_x) wrap_x = sum_x + span_x;
        else                     wrap_x = sum_x;
    end

    assign circ_on  = ((mode == MODE_AUTO) || (mode == MODE_AUTO_ALT)) && (span != '0);
    assign next_idx = circ_on ? wrap_x[AW-1:0] : sum_x[AW-1:0];

    assign rev_full = reverse_low(MAX_AW'(cur_idx), BREV_BITS);
    assign addr     = (mode == MODE_BITREV) ? rev_full[AW-1:0] : cur_idx;

endmodule

// File: rtl/cbag_top.sv
module cbag_top
    import cbag_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NSETS     = 4,
    parameter int BREV_BITS = 8,
    localparam int SW       = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int NBANKS   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bank_sel,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_set,
    input  logic [1:0]    wr_field,
    input  logic [AW-1:0] wr_data,
    input  logic [SW-1:0] rd_set,
    input  logic [1:0]    rd_field,
    output logic [AW-1:0] rd_data,
    input  logic          acc_valid,
    input  logic [SW-1:0] acc_set,
    input  logic [1:0]    acc_mode,
    input  logic          acc_use_imm,
    input  logic [AW-1:0] acc_imm,
    output logic          addr_valid,
    output logic [AW-1:0] addr_out
);

    logic          active_q;
    logic [AW-1:0] bk_rd   [NBANKS];
    logic [AW-1:0] bk_idx  [NBANKS];
    logic [AW-1:0] bk_step [NBANKS];
    logic [AW-1:0] bk_base [NBANKS];
    logic [AW-1:0] bk_span [NBANKS];

    logic [AW-1:0] cur_idx, cur_step, cur_base, cur_span, step_eff;
    logic [AW-1:0] next_idx, next_addr;
    mode_e         mode;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= bank_sel;
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        cbag_bank #(.AW(AW), .NSETS(NSETS)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (active_q == 1'(b))),
            .wr_set   (wr_set),
            .wr_field (field_e'(wr_field)),
            .wr_data  (wr_data),
            .upd_en   (acc_valid && (active_q == 1'(b))),
            .upd_set  (acc_set),
            .upd_idx  (next_idx),
            .rd_set   (rd_set),
            .rd_field (field_e'(rd_field)),
            .rd_data  (bk_rd[b]),
            .acc_set  (acc_set),
            .acc_idx  (bk_idx[b]),
            .acc_step (bk_step[b]),
            .acc_base (bk_base[b]),
            .acc_span (bk_span[b])
        );
    end

    assign rd_data  = bk_rd[active_q];
    assign cur_idx  = bk_idx[active_q];
    assign cur_step = bk_step[active_q];
    assign cur_base = bk_base[active_q];
    assign cur_span = bk_span[active_q];
    assign step_eff = acc_use_imm ? acc_imm : cur_step;
    assign mode     = mode_e'(acc_mode);

    cbag_update #(.AW(AW), .BREV_BITS(BREV_BITS)) u_update (
        .mode     (mode),
        .cur_idx  (cur_idx),
        .step     (step_eff),
        .base     (cur_base),
        .span     (cur_span),
        .next_idx (next_idx),
        .addr     (next_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
        end else begin
            addr_valid <= acc_valid;
            if (acc_valid) addr_out <= next_addr;
        end
    end

endmodule

// File: rtl/cbag_chk.sv
module cbag_chk #(
    parameter int AW        = 32,
    parameter int BREV_BITS = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          acc_valid,
    input logic [1:0]    acc_mode,
    input logic          acc_use_imm,
    input logic [AW-1:0] acc_imm,
    input logic [AW-1:0] cur_idx,
    input logic [AW-1:0] cur_step,
    input logic [AW-1:0] cur_base,
    input logic [AW-1:0] cur_span,
    input logic [AW-1:0] next_idx,
    input logic          addr_valid,
    input logic [AW-1:0] addr_out
);

    logic [AW-1:0] stp, stp_mag;
    logic [AW:0]   hi_x;
    logic          in_buf, step_ok, circ_req, nxt_in;

    assign stp      = acc_use_imm ? acc_imm : cur_step;
    assign stp_mag  = stp[AW-1] ? (~stp + 1'b1) : stp;
    assign hi_x     = {1'b0, cur_base} + {1'b0, cur_span};
    assign in_buf   = ({1'b0, cur_idx} >= {1'b0, cur_base}) && ({1'b0, cur_idx} < hi_x);
    assign step_ok  = stp_mag <= cur_span;
    assign circ_req = acc_valid && (acc_mode != 2'd1) && (acc_mode != 2'd2) && (cur_span != '0);
    assign nxt_in   = ({1'b0, next_idx} >= {1'b0, cur_base}) && ({1'b0, next_idx} < hi_x);

    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> addr_valid);                                             // R3
    AST_NO_REQ_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !addr_valid);                                           // R3
    AST_POST_MODIFY_ADDR: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mode != 2'd1) |=> (addr_out == $past(cur_idx)));     // R3
    AST_CIRC_STAYS_INSIDE: assert property (@(posedge clk) disable iff (rst)
        (circ_req && in_buf && step_ok) |-> nxt_in);                           // R5
    AST_BREV_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mode == 2'd1) |=>
            (addr_out[AW-1:BREV_BITS] == $past(cur_idx[AW-1:BREV_BITS])));     // R8
    AST_BREV_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mode == 2'd1) |=>
            ($countones(addr_out[BREV_BITS-1:0]) == $countones($past(cur_idx[BREV_BITS-1:0])))); // R8

endmodule

bind cbag_top cbag_chk #(.AW(AW), .BREV_BITS(BREV_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_mode    (acc_mode),
    .acc_use_imm (acc_use_imm),
    .acc_imm     (acc_imm),
    .cur_idx     (cur_idx),
    .cur_step    (cur_step),
    .cur_base    (cur_base),
    .cur_span    (cur_span),
    .next_idx    (next_idx),
    .addr_valid  (addr_valid),
    .addr_out    (addr_out)
);

// File: tb/tb_cbag_top.sv
module tb_cbag_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int NS = 4;
    localparam int SW = 2;
    localparam int BB = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bank_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_set = '0;
    logic [1:0]    wr_field = '0;
    logic [AW-1:0] wr_data = '0;
    logic [SW-1:0] rd_set = '0;
    logic [1:0]    rd_field = '0;
    logic [AW-1:0] rd_data;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic [1:0]    acc_mode = '0;
    logic          acc_use_imm = 1'b0;
    logic [AW-1:0] acc_imm = '0;
    logic          addr_valid;
    logic [AW-1:0] addr_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // shadow model of both banks
    logic [AW-1:0] mI [2][NS];
    logic [AW-1:0] mM [2][NS];
    logic [AW-1:0] mB [2][NS];
    logic [AW-1:0] mL [2][NS];
    int            mbank = 0;

    logic [AW-1:0] exp_q [$];
    string         tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cbag_top #(.AW(AW), .NSETS(NS), .BREV_BITS(BB)) dut (
        .clk(clk), .rst(rst), .bank_sel(bank_sel),
        .wr_en(wr_en), .wr_set(wr_set), .wr_field(wr_field), .wr_data(wr_data),
        .rd_set(rd_set), .rd_field(rd_field), .rd_data(rd_data),
        .acc_valid(acc_valid), .acc_set(acc_set), .acc_mode(acc_mode),
        .acc_use_imm(acc_use_imm), .acc_imm(acc_imm),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_step(input logic [1:0] mode, input logic [AW-1:0] i,
                                       input logic [AW-1:0] m, input logic [AW-1:0] b,
                                       input logic [AW-1:0] l,
                                       output logic [AW-1:0] a, output logic [AW-1:0] ni);
        logic signed [AW+1:0] s;
        s = $signed({2'b00, i}) + $signed({{2{m[AW-1]}}, m});
        a = i;
        if (mode == 2'd1) begin
            for (int k = 0; k < BB; k++) a[k] = i[BB-1-k];
        end
        if (mode == 2'd0 || mode == 2'd3) begin
            if (l != '0) begin
                if (s >= $signed({2'b00, b}) + $signed({2'b00, l})) s = s - $signed({2'b00, l});
                else if (s < $signed({2'b00, b}))                   s = s + $signed({2'b00, l});
            end
        end
        ni = s[AW-1:0];
    endfunction

    task automatic wr_reg(input int set, input int fld, input logic [AW-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_set = SW'(set); wr_field = 2'(fld); wr_data = val;
        @(posedge clk); #1;
        wr_en = 1'b0;
        case (fld)
            0: mI[mbank][set] = val;
            1: mM[mbank][set] = val;
            2: begin mB[mbank][set] = val; mI[mbank][set] = val; end
            default: mL[mbank][set] = val;
        endcase
    endtask

    task automatic chk_reg(input int set, input int fld, input string tag);
        logic [AW-1:0] e;
        @(negedge clk);
        rd_set = SW'(set); rd_field = 2'(fld);
        #1;
        case (fld)
            0: e = mI[mbank][set];
            1: e = mM[mbank][set];
            2: e = mB[mbank][set];
            default: e = mL[mbank][set];
        endcase
        check(tag, rd_data, e);
    endtask

    // one access; optional same-cycle bank request and same-cycle index write
    task automatic access_full(input int set, input logic [1:0] mode, input bit use_imm,
                               input logic [AW-1:0] imm, input string tag,
                               input int new_bank, input bit do_wr, input logic [AW-1:0] wval);
        logic [AW-1:0] a, ni;
        model_step(mode, mI[mbank][set], use_imm ? imm : mM[mbank][set],
                   mB[mbank][set], mL[mbank][set], a, ni);
        exp_q.push_back(a);
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_set = SW'(set); acc_mode = mode;
        acc_use_imm = use_imm; acc_imm = imm;
        bank_sel = new_bank[0];
        if (do_wr) begin
            wr_en = 1'b1; wr_set = SW'(set); wr_field = 2'd0; wr_data = wval;
        end
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_use_imm = 1'b0; wr_en = 1'b0;
        mI[mbank][set] = do_wr ? wval : ni;
        mbank = new_bank;
    endtask

    task automatic access(input int set, input logic [1:0] mode, input string tag);
        access_full(set, mode, 1'b0, '0, tag, mbank, 1'b0, '0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && addr_valid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected addr_valid", {{(AW-1){1'b0}}, addr_valid}, '0);
            end else begin
                string t;
                logic [AW-1:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, addr_out, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < NS; s++) begin
                mI[b][s] = '0; mM[b][s] = '0; mB[b][s] = '0; mL[b][s] = '0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        check("R1 addr_valid after reset", {{(AW-1){1'b0}}, addr_valid}, '0);
        for (int f = 0; f < 4; f++) chk_reg(0, f, "R1 set0 field reset");
        for (int f = 0; f < 4; f++) chk_reg(3, f, "R1 set3 field reset");

        // R2: write/readback, base loads index
        wr_reg(1, 1, 32'h0000_0011);
        wr_reg(1, 3, 32'h0000_0022);
        wr_reg(1, 0, 32'h0000_0033);
        wr_reg(1, 2, 32'h0000_4000);
        for (int f = 0; f < 4; f++) chk_reg(1, f, "R2 readback set1");

        // R3 R4: linear post-modify with span 0
        wr_reg(0, 2, 32'h0000_0100);
        wr_reg(0, 1, 32'h0000_0004);
        for (int k = 0; k < 3; k++) access(0, 2'd0, "R3 R4 linear addr");
        chk_reg(0, 0, "R4 linear index");
        wr_reg(0, 0, 32'hFFFF_FFFC);
        wr_reg(0, 1, 32'h0000_0008);
        access(0, 2'd0, "R4 linear top addr");
        chk_reg(0, 0, "R4 linear wraps modulo 2^AW");

        // R5: circular, odd base and span, upward
        wr_reg(1, 2, 32'h0000_1003);
        wr_reg(1, 3, 32'h0000_0005);
        wr_reg(1, 1, 32'h0000_0002);
        for (int k = 0; k < 7; k++) access(1, 2'd0, "R5 circular up addr");
        chk_reg(1, 0, "R5 circular index");

        // R6: circular downward with negative step
        wr_reg(2, 2, 32'h0000_0200);
        wr_reg(2, 3, 32'h0000_0007);
        wr_reg(2, 1, 32'hFFFF_FFFD);
        for (int k = 0; k < 6; k++) access(2, 2'd0, "R6 circular down addr");
        chk_reg(2, 0, "R6 circular index");

        // R7: immediate step, step register unchanged
        access_full(1, 2'd0, 1'b1, 32'hFFFF_FFFF, "R7 imm addr", mbank, 1'b0, '0);
        access_full(1, 2'd0, 1'b1, 32'hFFFF_FFFF, "R7 imm addr", mbank, 1'b0, '0);
        access(1, 2'd0, "R7 back to register step addr");
        chk_reg(1, 1, "R7 step register kept");
        chk_reg(1, 0, "R7 index after imm");

        // R8: bit-reverse output, linear index
        wr_reg(3, 0, 32'h00AB_0001);
        wr_reg(3, 1, 32'h0000_0001);
        for (int k = 0; k < 3; k++) access(3, 2'd1, "R8 bitrev addr");
        wr_reg(3, 2, 32'h0000_0040);
        wr_reg(3, 3, 32'h0000_0004);
        for (int k = 0; k < 5; k++) access(3, 2'd1, "R8 bitrev addr no wrap");
        chk_reg(3, 0, "R8 bitrev index not wrapped");

        // R9: forced linear ignores span; mode 3 is auto
        for (int k = 0; k < 4; k++) access(1, 2'd2, "R9 forced linear addr");
        chk_reg(1, 0, "R9 forced linear index");
        wr_reg(1, 2, 32'h0000_1003);
        for (int k = 0; k < 4; k++) access(1, 2'd3, "R9 mode3 circular addr");
        chk_reg(1, 0, "R9 mode3 index");

        // R12: other sets untouched by the accesses above
        chk_reg(0, 0, "R12 set0 index untouched");
        chk_reg(2, 0, "R12 set2 index untouched");

        // R10: bank switch timing and retention
        access_full(1, 2'd0, 1'b0, '0, "R10 access in switch cycle uses old bank", 1, 1'b0, '0);
        chk_reg(1, 0, "R10 secondary set1 index empty");
        chk_reg(1, 2, "R10 secondary set1 base empty");
        wr_reg(1, 2, 32'h0000_5000);
        wr_reg(1, 1, 32'h0000_0010);
        access(1, 2'd0, "R10 secondary access addr");
        access(1, 2'd0, "R10 secondary access addr");
        access_full(1, 2'd0, 1'b0, '0, "R10 secondary access before switch back", 0, 1'b0, '0);
        for (int f = 0; f < 4; f++) chk_reg(1, f, "R10 primary set1 retained");
        access(1, 2'd0, "R10 primary access after switch back");

        // R11: same-cycle write to index wins
        access_full(2, 2'd0, 1'b0, '0, "R11 access with write, old addr", mbank, 1'b1, 32'h0000_0203);
        chk_reg(2, 0, "R11 written index kept");
        access(2, 2'd0, "R11 next addr from written index");

        repeat (3) @(negedge clk);
        check("R3 all expected addresses seen", AW'(exp_q.size()), '0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule